// File: doc/BRIEF.md
# Single-Error-Correcting (7,4) Codec

This block pairs a systematic (7,4) encoder with a single-error-correcting decoder built on one fixed parity-check matrix. The encoder takes a four-bit data word and produces a seven-bit codeword. The four data bits stay in their positions at the left, and three check bits follow them. The decoder takes a received seven-bit word and forms a three-bit syndrome. It looks for the matrix column that equals the syndrome and inverts that position. It then reports the corrected word, the four recovered data bits, the syndrome and an error flag.

Each half has a one-cycle pipeline. A valid pulse on the input produces a valid pulse on the output one clock later. The result registers load only on valid input cycles, so between results the outputs hold their last value. The two halves share a clock and reset and otherwise work independently. One half can run on its own, or both can run in the same cycle, for example on a loopback link.

Words are written MSB first: bit 6 of a seven-bit word is position 1 (the leftmost bit), and bit 3 of the data word is a1.

Top module: `sec74_codec`

## Requirements
- R1: The encoder output is {a1,a2,a3,a4,C1,C2,C3}, where a1 = data bit 3 and a4 = data bit 0. The check bits are C1 = a1^a3^a4, C2 = a1^a2^a4 and C3 = a1^a2^a3.
- R2: enc_valid_o is high in the cycle after the cycle in which enc_valid_i was sampled high. enc_code_o carries that input's codeword in the same cycle.
- R3: The syndrome output is {s1,s2,s3}, with s1 = r1^r3^r4^r5, s2 = r1^r2^r4^r6 and s3 = r1^r2^r3^r7. Here r1 is bit 6 of the received word and r7 is bit 0.
- R4: A zero syndrome gives a corrected word equal to the received word, and dec_err_o is 0.
- R5: A nonzero syndrome equal to the column of position j inverts position j, and dec_err_o is 1. The columns for positions 1 to 7, written as s1s2s3, are 111, 011, 101, 110, 100, 010, 001.
- R6: dec_data_o equals the leftmost four bits of the corrected word.
- R7: Received word 1001111 gives syndrome 110 and corrected word 1000111. A codeword with positions 1 and 7 both inverted gives syndrome 110 and is decoded as if position 4 alone were in error.
- R8: While rst is high at a clock edge, every output of both halves is cleared to zero at that edge.
- R9: After a cycle with the valid input low, the matching valid output is 0 and the data outputs of that half keep their previous values.
- R10: dec_valid_o is high exactly in the cycle after dec_valid_i was sampled high, and both halves can accept input in the same cycle without interfering with each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_valid_i | input | 1 | Encoder input valid |
| enc_data_i | input | 4 | Data word, bit 3 = a1 |
| enc_valid_o | output | 1 | Encoder result valid |
| enc_code_o | output | 7 | Systematic codeword, bit 6 = position 1 |
| dec_valid_i | input | 1 | Decoder input valid |
| dec_word_i | input | 7 | Received word, bit 6 = r1 |
| dec_valid_o | output | 1 | Decoder result valid |
| dec_word_o | output | 7 | Corrected word |
| dec_data_o | output | 4 | Data bits of the corrected word |
| dec_syn_o | output | 3 | Syndrome {s1,s2,s3} |
| dec_err_o | output | 1 | Syndrome was nonzero |

## Verification
The bench tries all sixteen codewords clean and with each of the seven single-bit errors. A swapped or wrong column would show up here as the wrong bit inverted, or as a two-bit difference from the sent codeword. It also drives the worked example and the double error at positions 1 and 7. A decoder that tried to flag or refuse that double error, rather than miscorrect position 4, would fail. Random received words check that the syndrome bit order is not reversed. Gaps in the valid input check that the outputs hold and that the valid signals do not stick high. Cycles where both halves run together catch any crosstalk between them.

// File: rtl/sec74_pkg.sv
package sec74_pkg;
  localparam int DATA_W = 4;
  localparam int PAR_W  = 3;
  localparam int CODE_W = DATA_W + PAR_W;

  typedef logic [DATA_W-1:0] data_t;
  typedef logic [PAR_W-1:0]  syn_t;
  typedef logic [CODE_W-1:0] word_t;

  // Columns of the data positions, position 1 in the most significant slot.
  localparam logic [DATA_W*PAR_W-1:0] DATA_COLS = {3'b111, 3'b011, 3'b101, 3'b110};

  // Column of position pos (0 = leftmost); check positions form the identity.
  function automatic syn_t column(input int pos);
    syn_t c;
    if (pos < DATA_W) c = DATA_COLS[(DATA_W-1-pos)*PAR_W +: PAR_W];
    else              c = syn_t'(1) << (CODE_W-1-pos);
    return c;
  endfunction

  // Row mask of check equation row (0 = s1) over the word bits.
  function automatic word_t row_mask(input int row);
    word_t m;
    syn_t  c;
    m = '0;
    for (int pos = 0; pos < CODE_W; pos++) begin
      c = column(pos);
      m[CODE_W-1-pos] = c[PAR_W-1-row];
    end
    return m;
  endfunction
endpackage

// File: rtl/sec74_encoder.sv
module sec74_encoder
  import sec74_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  valid_i,
  input  data_t data_i,
  output logic  valid_o,
  output word_t code_o
);
  syn_t  chk;
  word_t code_d;

  for (genvar row = 0; row < PAR_W; row++) begin : g_row
    localparam word_t MASK = row_mask(row);
    assign chk[PAR_W-1-row] = ^(data_i & MASK[CODE_W-1 -: DATA_W]);
  end

  assign code_d = {data_i, chk};

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      code_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) code_o <= code_d;
    end
  end
endmodule

// File: rtl/sec74_syndrome.sv
module sec74_syndrome
  import sec74_pkg::*;
(
  input  word_t word_i,
  output syn_t  syn_o
);
  for (genvar row = 0; row < PAR_W; row++) begin : g_row
    localparam word_t MASK = row_mask(row);
    assign syn_o[PAR_W-1-row] = ^(word_i & MASK);
  end
endmodule

// File: rtl/sec74_corrector.sv
module sec74_corrector
  import sec74_pkg::*;
(
  input  word_t word_i,
  input  syn_t  syn_i,
  output word_t word_o,
  output logic  err_o
);
  word_t flip;

  for (genvar pos = 0; pos < CODE_W; pos++) begin : g_pos
    localparam syn_t COL = column(pos);
    assign flip[CODE_W-1-pos] = (syn_i == COL);
  end

  assign word_o = word_i ^ flip;
  assign err_o  = |syn_i;
endmodule

// File: rtl/sec74_codec.sv
module sec74_codec
  import sec74_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              enc_valid_i,
  input  logic [DATA_W-1:0] enc_data_i,
  output logic              enc_valid_o,
  output logic [CODE_W-1:0] enc_code_o,
  input  logic              dec_valid_i,
  input  logic [CODE_W-1:0] dec_word_i,
  output logic              dec_valid_o,
  output logic [CODE_W-1:0] dec_word_o,
  output logic [DATA_W-1:0] dec_data_o,
  output logic [PAR_W-1:0]  dec_syn_o,
  output logic              dec_err_o
);
  syn_t  syn_d;
  word_t fix_d;
  logic  err_d;

  sec74_encoder u_enc (
    .clk     (clk),
    .rst     (rst),
    .valid_i (enc_valid_i),
    .data_i  (enc_data_i),
    .valid_o (enc_valid_o),
    .code_o  (enc_code_o)
  );

  sec74_syndrome u_syn (
    .word_i (dec_word_i),
    .syn_o  (syn_d)
  );

  sec74_corrector u_fix (
    .word_i (dec_word_i),
    .syn_i  (syn_d),
    .word_o (fix_d),
    .err_o  (err_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid_o <= 1'b0;
      dec_word_o  <= '0;
      dec_data_o  <= '0;
      dec_syn_o   <= '0;
      dec_err_o   <= 1'b0;
    end else begin
      dec_valid_o <= dec_valid_i;
      if (dec_valid_i) begin
        dec_word_o <= fix_d;
        dec_data_o <= fix_d[CODE_W-1 -: DATA_W];
        dec_syn_o  <= syn_d;
        dec_err_o  <= err_d;
      end
    end
  end
endmodule

// File: rtl/sec74_codec_chk.sv
module sec74_codec_chk
  import sec74_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              enc_valid_i,
  input logic [DATA_W-1:0] enc_data_i,
  input logic              enc_valid_o,
  input logic [CODE_W-1:0] enc_code_o,
  input logic              dec_valid_i,
  input logic [CODE_W-1:0] dec_word_i,
  input logic              dec_valid_o,
  input logic [CODE_W-1:0] dec_word_o,
  input logic [DATA_W-1:0] dec_data_o,
  input logic [PAR_W-1:0]  dec_syn_o,
  input logic              dec_err_o
);
  function automatic syn_t syn_of(input word_t w);
    syn_t s;
    for (int row = 0; row < PAR_W; row++) s[PAR_W-1-row] = ^(w & row_mask(row));
    return s;
  endfunction

  AST_ENC_LATENCY: assert property (@(posedge clk) disable iff (rst)
    enc_valid_i |=> enc_valid_o) else $error("enc valid lost"); // R2
  AST_ENC_DATA_KEPT: assert property (@(posedge clk) disable iff (rst)
    enc_valid_i |=> enc_code_o[CODE_W-1 -: DATA_W] == $past(enc_data_i)) else $error("enc data"); // R1
  AST_ENC_IS_CODEWORD: assert property (@(posedge clk) disable iff (rst)
    enc_valid_o |-> syn_of(enc_code_o) == '0) else $error("enc parity"); // R1
  AST_DEC_LATENCY: assert property (@(posedge clk) disable iff (rst)
    dec_valid_i |=> dec_valid_o) else $error("dec valid lost"); // R10
  AST_DEC_IDLE: assert property (@(posedge clk) disable iff (rst)
    !dec_valid_i |=> !dec_valid_o && $stable(dec_word_o)) else $error("dec hold"); // R9
  AST_CLEAN_PASS: assert property (@(posedge clk) disable iff (rst)
    dec_valid_i && syn_of(dec_word_i) == '0 |=> dec_word_o == $past(dec_word_i) && !dec_err_o)
    else $error("clean word altered"); // R4
  AST_ONE_FLIP: assert property (@(posedge clk) disable iff (rst)
    dec_valid_i && syn_of(dec_word_i) != '0 |=>
      $countones(dec_word_o ^ $past(dec_word_i)) == 1 && dec_err_o) else $error("flip count"); // R5
  AST_DEC_IS_CODEWORD: assert property (@(posedge clk) disable iff (rst)
    dec_valid_o |-> syn_of(dec_word_o) == '0) else $error("dec not codeword"); // R5
  AST_DATA_FIELD: assert property (@(posedge clk) disable iff (rst)
    dec_valid_o |-> dec_data_o == dec_word_o[CODE_W-1 -: DATA_W]) else $error("data field"); // R6
endmodule

bind sec74_codec sec74_codec_chk chk_i (.*);

// File: tb/sec74_codec_tb_top.sv
module sec74_codec_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic       enc_valid_i = 1'b0;
  logic [3:0] enc_data_i  = '0;
  logic       enc_valid_o;
  logic [6:0] enc_code_o;
  logic       dec_valid_i = 1'b0;
  logic [6:0] dec_word_i  = '0;
  logic       dec_valid_o;
  logic [6:0] dec_word_o;
  logic [3:0] dec_data_o;
  logic [2:0] dec_syn_o;
  logic       dec_err_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sec74_codec dut_i (.*);

  function automatic logic [6:0] ref_enc(input logic [3:0] d);
    logic a1, a2, a3, a4;
    {a1, a2, a3, a4} = d;
    return {d, a1 ^ a3 ^ a4, a1 ^ a2 ^ a4, a1 ^ a2 ^ a3};
  endfunction

  function automatic logic [2:0] ref_syn(input logic [6:0] r);
    logic r1, r2, r3, r4, r5, r6, r7;
    {r1, r2, r3, r4, r5, r6, r7} = r;
    return {r1 ^ r3 ^ r4 ^ r5, r1 ^ r2 ^ r4 ^ r6, r1 ^ r2 ^ r3 ^ r7};
  endfunction

  function automatic logic [6:0] ref_fix(input logic [6:0] r);
    logic [2:0] s;
    s = ref_syn(r);
    if (s == 3'b000) return r;
    for (int p = 0; p < 7; p++)
      if (ref_syn(7'b1 << p) == s) return r ^ (7'b1 << p);
    return r;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  task automatic do_dec(input logic [6:0] w, input string req);
    logic [6:0] f;
    @(negedge clk);
    dec_valid_i = 1'b1; dec_word_i = w;
    @(negedge clk);
    dec_valid_i = 1'b0;
    f = ref_fix(w);
    chk({req, " R10 valid"}, 16'(dec_valid_o), 16'd1);
    chk({req, " R3 syndrome"}, 16'(dec_syn_o), 16'(ref_syn(w)));
    chk({req, " R4/R5 word"}, 16'(dec_word_o), 16'(f));
    chk({req, " R5 flag"}, 16'(dec_err_o), 16'(ref_syn(w) != 3'b000));
    chk({req, " R6 data"}, 16'(dec_data_o), 16'(f[6:3]));
  endtask

  task automatic do_enc(input logic [3:0] d);
    @(negedge clk);
    enc_valid_i = 1'b1; enc_data_i = d;
    @(negedge clk);
    enc_valid_i = 1'b0;
    chk("R2 enc valid", 16'(enc_valid_o), 16'd1);
    chk("R1 codeword", 16'(enc_code_o), 16'(ref_enc(d)));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin : main
    logic [6:0] w;
    void'($urandom(32'h5EC74));
    // R8: reset clears while inputs are active
    enc_valid_i = 1'b1; enc_data_i = 4'hF; dec_valid_i = 1'b1; dec_word_i = 7'h7F;
    repeat (3) @(negedge clk);
    chk("R8 enc_valid_o", 16'(enc_valid_o), 16'd0);
    chk("R8 enc_code_o", 16'(enc_code_o), 16'd0);
    chk("R8 dec_valid_o", 16'(dec_valid_o), 16'd0);
    chk("R8 dec outputs", 16'({dec_word_o, dec_data_o, dec_syn_o, dec_err_o}), 16'd0);
    enc_valid_i = 1'b0; dec_valid_i = 1'b0;
    rst = 1'b0;

    // R1/R2: every data word
    for (int d = 0; d < 16; d++) do_enc(4'(d));

    // R9: idle cycle holds values and drops valid
    @(negedge clk);
    chk("R9 enc valid low", 16'(enc_valid_o), 16'd0);
    chk("R9 enc hold", 16'(enc_code_o), 16'(ref_enc(4'hF)));

    // R4/R5: each codeword clean and with each single error
    for (int d = 0; d < 16; d++) begin
      do_dec(ref_enc(4'(d)), "clean");
      for (int p = 0; p < 7; p++) begin
        do_dec(ref_enc(4'(d)) ^ (7'b1 << p), "single");
        chk("R5 recovered data", 16'(dec_data_o), 16'(d));
      end
    end

    // R7: worked example and the double error at positions 1 and 7
    do_dec(7'b1001111, "R7 example");
    chk("R7 example syndrome", 16'(dec_syn_o), 16'b110);
    chk("R7 example word", 16'(dec_word_o), 16'b1000111);
    w = ref_enc(4'b1011) ^ 7'b1000001;
    do_dec(w, "R7 double");
    chk("R7 double syndrome", 16'(dec_syn_o), 16'b110);
    chk("R7 double miscorrect", 16'(dec_word_o), 16'(w ^ 7'b0001000));
    chk("R7 double flag", 16'(dec_err_o), 16'd1);

    // R9: decoder hold after idle cycle
    @(negedge clk);
    chk("R9 dec valid low", 16'(dec_valid_o), 16'd0);
    chk("R9 dec hold", 16'(dec_word_o), 16'(w ^ 7'b0001000));

    // R3: random received words
    for (int i = 0; i < 200; i++) do_dec(7'($urandom), "random");

    // R10: both halves in the same cycle, back to back
    for (int i = 0; i < 20; i++) begin
      logic [3:0] d;
      d = 4'($urandom);
      w = 7'($urandom);
      @(negedge clk);
      enc_valid_i = 1'b1; enc_data_i = d; dec_valid_i = 1'b1; dec_word_i = w;
      @(negedge clk);
      chk("R10 enc codeword", 16'(enc_code_o), 16'(ref_enc(d)));
      chk("R10 dec word", 16'(dec_word_o), 16'(ref_fix(w)));
      chk("R10 both valid", 16'({enc_valid_o, dec_valid_o}), 16'b11);
    end
    enc_valid_i = 1'b0; dec_valid_i = 1'b0;
    @(negedge clk);
    chk("R10 valids drop", 16'({enc_valid_o, dec_valid_o}), 16'b00);

    done = 1;
    summary();
    $finish;
  end
endmodule